// File: doc/BRIEF.md
# Five-Port Single-Flit Mesh Switch

This block is one tile switch in a two-dimensional mesh that moves single-flit packets between compute tiles. A flit is 84 bits wide. The upper 20 bits are a destination node number and the lower 64 bits are an opaque payload. The switch reads the tile coordinates from fixed low-order fields of the node number. It takes the X field from the lowest bits and the Y field from the bits just above it. It forwards the flit with dimension-ordered routing: it corrects X first, then corrects Y, and delivers the flit to the local port once both coordinates match the tile's own.

Each of the five ports (local, east, west, north, south) has an input stream and an output stream. Every stream uses a valid/ready handshake. A flit moves on a clock edge where valid and ready are both high. A sender must hold valid and data steady until that edge. The switch raises an input's ready only while it is taking that flit in the current cycle, so ready may depend on valid. Internally, a split stage decodes the route of each input. A merge stage per output then picks one requester by round robin and loads it into an output register. That register drives the outgoing link directly. It refills in the cycle it drains, and it keeps its flit for as long as the downstream ready stays low.

Top module: `mesh_switch`

## Requirements
- R1: A flit whose destination X (node bits [X_W-1:0]) is greater than the tile X leaves on the east output (port index 1), whatever its Y.
- R2: A flit whose destination X is less than the tile X leaves on the west output (port index 2), whatever its Y.
- R3: With X equal, a destination Y (node bits [X_W+Y_W-1:X_W]) greater than the tile Y selects the north output (index 3), and a smaller Y selects the south output (index 4).
- R4: A flit whose X and Y both equal the tile coordinates leaves on the local output (index 0).
- R5: Node-number bits above X_W+Y_W have no effect on the route, and all 84 bits of the flit arrive at the output unchanged.
- R6: A flit accepted on a clock edge is presented on its output from the next edge onward, and it is presented there exactly once.
- R7: While an output holds valid with ready low, its valid and data stay unchanged. Inputs that want that output see ready low. No flit is dropped or duplicated, and an input's ready is never high without its valid.
- R8: The arbiter at each output grants the first requester found by scanning input indices cyclically upward, starting one above the last input granted at that output (starting at index 0 after reset).
- R9: While reset is asserted, every output valid is low, including outputs that held a flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | Per-input flit valid (index 0 local, 1 east, 2 west, 3 north, 4 south) |
| in_ready | output | 5 | Per-input acceptance in this cycle |
| in_data | input | 5 x 84 | Per-input flit: node number [83:64], payload [63:0] |
| out_valid | output | 5 | Per-output flit valid |
| out_ready | input | 5 | Per-output downstream ready |
| out_data | output | 5 x 84 | Per-output registered flit |

## Verification
The bench builds the switch with 2-bit X and Y fields and the tile placed at (1,1). With that setting, destinations on either side of the tile in both dimensions fit in a small node number, so every output direction is reachable. Because the coordinate fields cover only four bits, the node number keeps sixteen upper bits free, and the bench fills them with arbitrary values to show they play no part in routing. With the tile in the middle of that 4x4 range, the tests can place contention and stalls on a single output and follow the round-robin order across all five inputs.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
  localparam int NPORT      = 5;
  localparam int PORT_LOCAL = 0;
  localparam int PORT_EAST  = 1;
  localparam int PORT_WEST  = 2;
  localparam int PORT_NORTH = 3;
  localparam int PORT_SOUTH = 4;
endpackage

// File: rtl/mesh_split.sv
module mesh_split
  import mesh_pkg::*;
#(
  parameter int X_W  = 4,
  parameter int Y_W  = 4,
  parameter int MY_X = 0,
  parameter int MY_Y = 0
) (
  input  logic             valid,
  input  logic [X_W-1:0]   dst_x,
  input  logic [Y_W-1:0]   dst_y,
  output logic [NPORT-1:0] req
);
  localparam logic [X_W-1:0] TILE_X = MY_X[X_W-1:0];
  localparam logic [Y_W-1:0] TILE_Y = MY_Y[Y_W-1:0];

  always_comb begin
    req = '0;
    if (valid) begin
      if (dst_x > TILE_X)      req[PORT_EAST]  = 1'b1;
      else if (dst_x < TILE_X) req[PORT_WEST]  = 1'b1;
      else if (dst_y > TILE_Y) req[PORT_NORTH] = 1'b1;
      else if (dst_y < TILE_Y) req[PORT_SOUTH] = 1'b1;
      else                     req[PORT_LOCAL] = 1'b1;
    end
  end
endmodule

// File: rtl/mesh_merge.sv
module mesh_merge #(
  parameter int FLIT_W = 84,
  parameter int NIN    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NIN-1:0]            req,
  input  logic [NIN-1:0][FLIT_W-1:0] in_flit,
  output logic [NIN-1:0]            grant,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [FLIT_W-1:0]         out_flit
);
  localparam int PTR_W = (NIN > 1) ? $clog2(NIN) : 1;

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] sel;
  logic             found;
  logic             can_load;

  assign can_load = !out_valid || out_ready;

  always_comb begin
    grant = '0;
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < NIN; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NIN;
      if (!found && req[idx] && can_load) begin
        grant[idx] = 1'b1;
        sel        = idx[PTR_W-1:0];
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ptr       <= '0;
    end else if (found) begin
      out_valid <= 1'b1;
      ptr       <= (int'(sel) == NIN - 1) ? '0 : sel + 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (found) out_flit <= in_flit[sel];
  end
endmodule

// File: rtl/mesh_switch.sv
module mesh_switch
  import mesh_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 20,
  parameter int X_W    = 4,
  parameter int Y_W    = 4,
  parameter int MY_X   = 0,
  parameter int MY_Y   = 0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NPORT-1:0]                      in_valid,
  output logic [NPORT-1:0]                      in_ready,
  input  logic [NPORT-1:0][DATA_W+ADDR_W-1:0]   in_data,
  output logic [NPORT-1:0]                      out_valid,
  input  logic [NPORT-1:0]                      out_ready,
  output logic [NPORT-1:0][DATA_W+ADDR_W-1:0]   out_data
);
  localparam int FLIT_W = DATA_W + ADDR_W;

  logic [NPORT-1:0][NPORT-1:0] req_by_in;
  logic [NPORT-1:0][NPORT-1:0] req_by_out;
  logic [NPORT-1:0][NPORT-1:0] gnt_by_out;

  for (genvar i = 0; i < NPORT; i++) begin : g_split
    mesh_split #(
      .X_W (X_W),
      .Y_W (Y_W),
      .MY_X(MY_X),
      .MY_Y(MY_Y)
    ) u_split (
      .valid(in_valid[i]),
      .dst_x(in_data[i][DATA_W +: X_W]),
      .dst_y(in_data[i][DATA_W+X_W +: Y_W]),
      .req  (req_by_in[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req_by_out[o][i] = req_by_in[i][o];
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_merge
    mesh_merge #(
      .FLIT_W(FLIT_W),
      .NIN   (NPORT)
    ) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_by_out[o]),
      .in_flit  (in_data),
      .grant    (gnt_by_out[o]),
      .out_valid(out_valid[o]),
      .out_ready(out_ready[o]),
      .out_flit (out_data[o])
    );
  end

  always_comb begin
    in_ready = '0;
    for (int o = 0; o < NPORT; o++)
      in_ready = in_ready | gnt_by_out[o];
  end
endmodule

// File: rtl/mesh_switch_chk.sv
module mesh_switch_chk
  import mesh_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 20,
  parameter int X_W    = 4,
  parameter int Y_W    = 4,
  parameter int MY_X   = 0,
  parameter int MY_Y   = 0
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [NPORT-1:0]                    in_valid,
  input logic [NPORT-1:0]                    in_ready,
  input logic [NPORT-1:0][DATA_W+ADDR_W-1:0] in_data,
  input logic [NPORT-1:0]                    out_valid,
  input logic [NPORT-1:0]                    out_ready,
  input logic [NPORT-1:0][DATA_W+ADDR_W-1:0] out_data
);
  function automatic int route_of(input logic [DATA_W+ADDR_W-1:0] f);
    int x, y;
    x = int'(f[DATA_W +: X_W]);
    y = int'(f[DATA_W+X_W +: Y_W]);
    if (x != MY_X) return (x > MY_X) ? PORT_EAST : PORT_WEST;
    if (y != MY_Y) return (y > MY_Y) ? PORT_NORTH : PORT_SOUTH;
    return PORT_LOCAL;
  endfunction

  logic [NPORT-1:0][NPORT-1:0] acc_to;

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        acc_to[o][i] = in_valid[i] && in_ready[i] && (route_of(in_data[i]) == o);
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_data[o])); // R7
    AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(acc_to[o]) <= 1); // R7
    for (genvar i = 0; i < NPORT; i++) begin : g_in
      AST_FORWARD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_to[o][i] |=> out_valid[o] && out_data[o] == $past(in_data[i])); // R6
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_rdy
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> in_valid[i]); // R7
  end
endmodule

bind mesh_switch mesh_switch_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/mesh_switch_bench.sv
module mesh_switch_bench;
  localparam int NP = 5;
  localparam int FW = 84;
  localparam int NV = 12;

  // entry: {src[2:0], node[19:0], payload[63:0], expected_out[2:0]}
  localparam logic [89:0] VEC [NV] = '{
    {3'd0, 20'h00006, 64'h1111_0000_0000_0001, 3'd1},
    {3'd1, 20'h0000C, 64'h2222_0000_0000_0002, 3'd2},
    {3'd2, 20'h00009, 64'h3333_0000_0000_0003, 3'd3},
    {3'd3, 20'h00001, 64'h4444_0000_0000_0004, 3'd4},
    {3'd4, 20'h00005, 64'h5555_0000_0000_0005, 3'd0},
    {3'd0, 20'h00003, 64'h6666_0000_0000_0006, 3'd1},
    {3'd2, 20'h00000, 64'h7777_0000_0000_0007, 3'd2},
    {3'd0, 20'h0000D, 64'h8888_0000_0000_0008, 3'd3},
    {3'd1, 20'hABCD5, 64'h9999_0000_0000_0009, 3'd0},
    {3'd3, 20'hFFFF6, 64'hAAAA_0000_0000_000A, 3'd1},
    {3'd4, 20'h00005, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0},
    {3'd1, 20'h12349, 64'hBBBB_0000_0000_000B, 3'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] in_valid = '0;
  logic [NP-1:0] in_ready;
  logic [NP-1:0][FW-1:0] in_data = '0;
  logic [NP-1:0] out_valid;
  logic [NP-1:0] out_ready = '1;
  logic [NP-1:0][FW-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mesh_switch #(.X_W(2), .Y_W(2), .MY_X(1), .MY_Y(1)) u_mesh_switch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] fa, fb;
    int src, exp;
    string tag;

    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R9", FW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: routing, payload integrity, one-cycle latency
    for (int v = 0; v < NV; v++) begin
      src = int'(VEC[v][89:87]);
      exp = int'(VEC[v][2:0]);
      tag = (exp == 1) ? "R1" : (exp == 2) ? "R2" : (exp == 0) ? "R4" : "R3";
      in_valid[src] = 1'b1;
      in_data[src]  = VEC[v][86:3];
      #1;
      chk(in_ready[src], "R6 accept", FW'(in_ready), FW'(1 << src));
      @(posedge clk);
      @(negedge clk);
      in_valid[src] = 1'b0;
      chk(out_valid == NP'(1 << exp), tag, FW'(out_valid), FW'(1 << exp));
      if (v >= 8)
        chk(out_data[exp] == VEC[v][86:3], "R5", out_data[exp], VEC[v][86:3]);
      else
        chk(out_data[exp] == VEC[v][86:3], tag, out_data[exp], VEC[v][86:3]);
    end
    @(negedge clk);
    chk(out_valid == '0, "R6 once", FW'(out_valid), '0);

    // stall on east output
    fa = {20'h00006, 64'hA0A0_0000_0000_00A0};
    fb = {20'h00007, 64'hB0B0_0000_0000_00B0};
    out_ready[1] = 1'b0;
    in_valid[0] = 1'b1; in_data[0] = fa;
    @(posedge clk); @(negedge clk);
    in_valid[0] = 1'b0;
    in_valid[2] = 1'b1; in_data[2] = fb;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(in_ready[2] == 1'b0, "R7 blocked", FW'(in_ready[2]), '0);
      chk(out_valid[1] && out_data[1] == fa, "R7 hold", out_data[1], fa);
      @(negedge clk);
    end
    out_ready[1] = 1'b1;
    #1;
    chk(in_ready[2] == 1'b1, "R7 refill", FW'(in_ready[2]), 1);
    @(posedge clk); @(negedge clk);
    in_valid[2] = 1'b0;
    chk(out_valid[1] && out_data[1] == fb, "R7 next", out_data[1], fb);
    @(negedge clk);
    chk(out_valid[1] == 1'b0, "R7 no dup", FW'(out_valid[1]), '0);

    // round robin: all five inputs to local, pointer at 0
    for (int i = 0; i < NP; i++) begin
      in_valid[i] = 1'b1;
      in_data[i]  = {20'h00005, 64'(i)};
    end
    for (int c = 0; c < NP; c++) begin
      #1;
      chk(in_ready == NP'(1 << c), "R8 grant", FW'(in_ready), FW'(1 << c));
      @(posedge clk); @(negedge clk);
      in_valid[c] = 1'b0;
      chk(out_valid[0] && out_data[0][7:0] == 8'(c), "R8 order", out_data[0], FW'(c));
    end
    @(negedge clk);

    // round robin between inputs 1 and 3, re-armed after each grant
    in_valid[1] = 1'b1; in_data[1] = {20'h00005, 64'd1};
    in_valid[3] = 1'b1; in_data[3] = {20'h00005, 64'd3};
    for (int c = 0; c < 4; c++) begin
      int w;
      w = (c % 2 == 0) ? 1 : 3;
      #1;
      chk(in_ready == NP'(1 << w), "R8 alternate", FW'(in_ready), FW'(1 << w));
      @(posedge clk); @(negedge clk);
      chk(out_data[0][7:0] == 8'(w), "R8 alternate data", out_data[0], FW'(w));
    end
    in_valid = '0;

    // reset clears a held flit
    out_ready[4] = 1'b0;
    in_valid[0] = 1'b1; in_data[0] = {20'h00001, 64'hC};
    @(posedge clk); @(negedge clk);
    in_valid[0] = 1'b0;
    chk(out_valid[4] == 1'b1, "R3 south held", FW'(out_valid[4]), 1);
    rst_n = 1'b0;
    #1;
    chk(out_valid == '0, "R9", FW'(out_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = '1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule